// File: doc/BRIEF.md
# Message Trace Filter and Capture

This block sits beside a message network and watches every message that passes an observation point. While tracing is switched on, each message that passes the optional id filters becomes one trace record. The block sends that record out on a simple memory write port. The address comes from a write pointer that runs through a programmable region between a base address and a limit address. Addresses count in record slots, so one record advances the pointer by one.

The filters compare the message's 12-bit source id and 12-bit destination id against configured values. Each filter has its own enable. When both are on, a message must pass both. When neither is on, every message is recorded. A wrap setting picks one of two behaviours when the pointer reaches the limit. In circular mode the pointer goes back to the base. In one-shot mode capture stops and a sticky full flag is raised.

The write port holds one record at a time and waits for a ready signal. A matching message that arrives while an earlier record is still waiting is not recorded. It is counted as dropped instead.

Top module: `msg_trace_capture`

## Requirements
- R1: After reset, `wr_valid` is 0, `trace_full` is 0 and `drop_count` is 0.
- R2: While `cfg_enable` is 0, observed messages produce no write beat.
- R3: With both filter enables at 0, every observed message produces one write beat in the following cycle. Its `wr_data` is {source id in bits [55:44], destination id in bits [43:32], payload in bits [31:0]}.
- R4: With `cfg_dst_match_en` at 1, only messages whose destination id equals `cfg_dst_id` are recorded.
- R5: With `cfg_src_match_en` at 1, only messages whose source id equals `cfg_src_id` are recorded.
- R6: With both match enables at 1, a message is recorded only if both ids match.
- R7: The first record after `cfg_enable` rises is written at `cfg_base`. Each later record is written one address above the previous one.
- R8: With `cfg_wrap` at 1, the record after the one written at `cfg_limit` is written at `cfg_base`.
- R9: With `cfg_wrap` at 0, `trace_full` rises in the cycle the record at `cfg_limit` appears. Later messages are then ignored and not counted as dropped. A new rising edge of `cfg_enable` clears `trace_full` and restarts capture at `cfg_base`.
- R10: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R11: A matching message that arrives while a record is held and `wr_ready` is 0 is not written and does not consume an address. It increments `drop_count` by one. A rising edge of `cfg_enable` clears `drop_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Tracing on; a rising edge restarts capture |
| cfg_wrap | input | 1 | 1 = circular capture, 0 = stop at limit |
| cfg_dst_match_en | input | 1 | Enable destination id filter |
| cfg_dst_id | input | 12 | Destination id to match |
| cfg_src_match_en | input | 1 | Enable source id filter |
| cfg_src_id | input | 12 | Source id to match |
| cfg_base | input | ADDR_W | First record slot of the region |
| cfg_limit | input | ADDR_W | Last record slot of the region |
| obs_valid | input | 1 | A message is present this cycle |
| obs_src | input | 12 | Message source id |
| obs_dst | input | 12 | Message destination id |
| obs_payload | input | PAY_W | Message payload |
| wr_valid | output | 1 | Write beat present |
| wr_addr | output | ADDR_W | Record slot address |
| wr_data | output | 24+PAY_W | Packed record |
| wr_ready | input | 1 | Write port accepts the beat |
| trace_full | output | 1 | Sticky: one-shot region exhausted |
| drop_count | output | DROP_W | Matching messages lost to back-pressure |

## Verification
One register stage lies between the observe port and the write port, so a record is due on the clock edge after the message is presented. `trace_full` and `drop_count` change on that same edge. A rising edge of `cfg_enable` takes effect on the edge where it is first seen. The bench drives inputs on falling edges and samples on the next falling edge, half a period after the edge that updates the outputs. Each check therefore sees exactly one register update. The bench keeps its own model of the expected slot address and compares every beat against it.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ID_W = 12;
  typedef logic [ID_W-1:0] id_t;

  // A disabled filter passes every id; an enabled one needs equality.
  function automatic logic id_pass(input logic en, input id_t want, input id_t seen);
    return !en || (want == seen);
  endfunction
endpackage

// File: rtl/trc_match.sv
module trc_match
  import trc_pkg::*;
(
  input  logic src_en,
  input  id_t  src_cfg,
  input  id_t  src_obs,
  input  logic dst_en,
  input  id_t  dst_cfg,
  input  id_t  dst_obs,
  output logic hit
);
  logic src_ok, dst_ok;
  assign src_ok = id_pass(src_en, src_cfg, src_obs);
  assign dst_ok = id_pass(dst_en, dst_cfg, dst_obs);
  assign hit    = src_ok && dst_ok;
endmodule

// File: rtl/trc_wptr.sv
module trc_wptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              stopped,
  output logic              full
);
  logic [ADDR_W-1:0] ptr_q;
  logic              full_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] cur,
                                             input logic [ADDR_W-1:0] b,
                                             input logic [ADDR_W-1:0] l,
                                             input logic w);
    if (cur != l) return cur + 1'b1;
    return w ? b : cur;
  endfunction

  assign slot_addr = start ? base : ptr_q;
  assign stopped   = start ? 1'b0 : full_q;
  assign full      = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (advance) begin
      ptr_q  <= step(slot_addr, base, limit, wrap);
      full_q <= (slot_addr == limit) && !wrap;
    end else if (start) begin
      ptr_q  <= base;
      full_q <= 1'b0;
    end
  end

  // R9
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !start) |-> !advance);
  // R8
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && slot_addr == limit) |=> ptr_q == $past(base));
endmodule

// File: rtl/trc_drop_ctr.sv
module trc_drop_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (clear)                   count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/trc_out_reg.sv
module trc_out_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ready,
  output logic              slot_free,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= load_addr;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));
  // R3
  load_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
endmodule

// File: rtl/msg_trace_capture.sv
module msg_trace_capture
  import trc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAY_W  = 32,
  parameter int DROP_W = 16,
  localparam int REC_W = 2 * ID_W + PAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_wrap,
  input  logic              cfg_dst_match_en,
  input  logic [ID_W-1:0]   cfg_dst_id,
  input  logic              cfg_src_match_en,
  input  logic [ID_W-1:0]   cfg_src_id,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              obs_valid,
  input  logic [ID_W-1:0]   obs_src,
  input  logic [ID_W-1:0]   obs_dst,
  input  logic [PAY_W-1:0]  obs_payload,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REC_W-1:0]  wr_data,
  input  logic              wr_ready,
  output logic              trace_full,
  output logic [DROP_W-1:0] drop_count
);
  // Named internal events, visible to assertions.
  logic              en_q;
  logic              cap_start;
  logic              id_hit;
  logic              stopped;
  logic              slot_free;
  logic              candidate;
  logic              load_evt;
  logic              drop_evt;
  logic [ADDR_W-1:0] slot_addr;
  logic [REC_W-1:0]  record;

  function automatic logic [REC_W-1:0] pack_rec(input id_t s, input id_t d,
                                                input logic [PAY_W-1:0] p);
    return {s, d, p};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cfg_enable;
  end

  assign cap_start = cfg_enable && !en_q;
  assign candidate = cfg_enable && obs_valid && id_hit && !stopped;
  assign load_evt  = candidate && slot_free;
  assign drop_evt  = candidate && !slot_free;
  assign record    = pack_rec(obs_src, obs_dst, obs_payload);

  trc_match u_match (
    .src_en  (cfg_src_match_en),
    .src_cfg (cfg_src_id),
    .src_obs (obs_src),
    .dst_en  (cfg_dst_match_en),
    .dst_cfg (cfg_dst_id),
    .dst_obs (obs_dst),
    .hit     (id_hit)
  );

  trc_wptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cap_start),
    .advance   (load_evt),
    .wrap      (cfg_wrap),
    .base      (cfg_base),
    .limit     (cfg_limit),
    .slot_addr (slot_addr),
    .stopped   (stopped),
    .full      (trace_full)
  );

  trc_drop_ctr #(.CNT_W(DROP_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cap_start),
    .inc   (drop_evt),
    .count (drop_count)
  );

  trc_out_reg #(.ADDR_W(ADDR_W), .DATA_W(REC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_addr (slot_addr),
    .load_data (record),
    .ready     (wr_ready),
    .slot_free (slot_free),
    .valid     (wr_valid),
    .addr      (wr_addr),
    .data      (wr_data)
  );

  // R11
  load_or_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, drop_evt}));
  // R11
  drop_only_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (wr_valid && !wr_ready));
  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !load_evt);
  // R5
  src_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cfg_src_match_en) |-> obs_src == cfg_src_id);
  // R4
  dst_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cfg_dst_match_en) |-> obs_dst == cfg_dst_id);
endmodule

// File: tb/sim_msg_trace_capture.sv
module sim_msg_trace_capture;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int PW = 32;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b0, cfg_wrap = 1'b1;
  logic          cfg_dst_match_en = 1'b0, cfg_src_match_en = 1'b0;
  logic [11:0]   cfg_dst_id = '0, cfg_src_id = '0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic          obs_valid = 1'b0;
  logic [11:0]   obs_src = '0, obs_dst = '0;
  logic [PW-1:0] obs_payload = '0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [55:0]   wr_data;
  logic          wr_ready = 1'b1;
  logic          trace_full;
  logic [DW-1:0] drop_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_trace_capture #(.ADDR_W(AW), .PAY_W(PW), .DROP_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wrap(cfg_wrap),
    .cfg_dst_match_en(cfg_dst_match_en), .cfg_dst_id(cfg_dst_id),
    .cfg_src_match_en(cfg_src_match_en), .cfg_src_id(cfg_src_id),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .obs_valid(obs_valid),
    .obs_src(obs_src), .obs_dst(obs_dst), .obs_payload(obs_payload),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .trace_full(trace_full), .drop_count(drop_count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one message for one cycle; return at the falling edge after
  // the capturing clock edge, when the record is due.
  task automatic send(input logic [11:0] s, input logic [11:0] d, input logic [PW-1:0] p);
    @(negedge clk);
    obs_valid = 1'b1; obs_src = s; obs_dst = d; obs_payload = p;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  task automatic expect_rec(input string req, input logic [AW-1:0] a,
                            input logic [11:0] s, input logic [11:0] d, input logic [PW-1:0] p);
    check(req, {63'd0, wr_valid}, 64'd1);
    check(req, {48'd0, wr_addr}, {48'd0, a});
    check(req, {8'd0, wr_data}, {8'd0, s, d, p});
  endtask

  task automatic expect_none(input string req);
    check(req, {63'd0, wr_valid}, 64'd0);
  endtask

  task automatic restart(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic w);
    @(negedge clk);
    cfg_enable = 1'b0; cfg_base = b; cfg_limit = l; cfg_wrap = w;
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid", {63'd0, wr_valid}, 64'd0);
    check("R1 full", {63'd0, trace_full}, 64'd0);
    check("R1 drops", {48'd0, drop_count}, 64'd0);
  endtask

  task automatic t_disabled();
    send(12'h001, 12'h002, 32'h1111_0000);
    expect_none("R2");
  endtask

  task automatic t_nofilter();
    restart(16'h0010, 16'h001F, 1'b1);
    send(12'h123, 12'h456, 32'hDEAD_BEEF);
    expect_rec("R3 R7 first", 16'h0010, 12'h123, 12'h456, 32'hDEAD_BEEF);
    send(12'hFFF, 12'h000, 32'h0000_0001);
    expect_rec("R3 R7 second", 16'h0011, 12'hFFF, 12'h000, 32'h0000_0001);
    send(12'h000, 12'hFFF, 32'hA5A5_5A5A);
    expect_rec("R3 R7 third", 16'h0012, 12'h000, 12'hFFF, 32'hA5A5_5A5A);
  endtask

  task automatic t_dst();
    restart(16'h0020, 16'h002F, 1'b1);
    cfg_dst_match_en = 1'b1; cfg_dst_id = 12'h0AB;
    send(12'h111, 12'h0AC, 32'h2);
    expect_none("R4 miss");
    send(12'h111, 12'h0AB, 32'h3);
    expect_rec("R4 hit", 16'h0020, 12'h111, 12'h0AB, 32'h3);
    cfg_dst_match_en = 1'b0;
  endtask

  task automatic t_src();
    restart(16'h0030, 16'h003F, 1'b1);
    cfg_src_match_en = 1'b1; cfg_src_id = 12'h7C0;
    send(12'h7C1, 12'h222, 32'h4);
    expect_none("R5 miss");
    send(12'h7C0, 12'h222, 32'h5);
    expect_rec("R5 hit", 16'h0030, 12'h7C0, 12'h222, 32'h5);
    cfg_src_match_en = 1'b0;
  endtask

  task automatic t_both();
    restart(16'h0050, 16'h005F, 1'b1);
    cfg_src_match_en = 1'b1; cfg_src_id = 12'h0C3;
    cfg_dst_match_en = 1'b1; cfg_dst_id = 12'h3C0;
    send(12'h0C3, 12'h3C1, 32'h6);
    expect_none("R6 src only");
    send(12'h0C4, 12'h3C0, 32'h7);
    expect_none("R6 dst only");
    send(12'h0C3, 12'h3C0, 32'h8);
    expect_rec("R6 both", 16'h0050, 12'h0C3, 12'h3C0, 32'h8);
    cfg_src_match_en = 1'b0; cfg_dst_match_en = 1'b0;
  endtask

  task automatic t_wrap();
    restart(16'h0040, 16'h0042, 1'b1);
    for (int i = 0; i < 4; i++) begin
      send(12'h010, 12'h020, 32'(i));
      expect_rec("R8", (i == 3) ? 16'h0040 : 16'(16'h0040 + i), 12'h010, 12'h020, 32'(i));
    end
    check("R8 not full", {63'd0, trace_full}, 64'd0);
  endtask

  task automatic t_stop();
    restart(16'h0080, 16'h0081, 1'b0);
    send(12'h030, 12'h040, 32'hA);
    expect_rec("R9 a", 16'h0080, 12'h030, 12'h040, 32'hA);
    check("R9 not yet full", {63'd0, trace_full}, 64'd0);
    send(12'h030, 12'h040, 32'hB);
    expect_rec("R9 limit", 16'h0081, 12'h030, 12'h040, 32'hB);
    check("R9 full", {63'd0, trace_full}, 64'd1);
    send(12'h030, 12'h040, 32'hC);
    expect_none("R9 ignored");
    check("R9 no drop", {48'd0, drop_count}, 64'd0);
    restart(16'h0080, 16'h0081, 1'b0);
    check("R9 cleared", {63'd0, trace_full}, 64'd0);
    send(12'h030, 12'h040, 32'hD);
    expect_rec("R9 restart", 16'h0080, 12'h030, 12'h040, 32'hD);
  endtask

  task automatic t_stall();
    restart(16'h0100, 16'h01FF, 1'b1);
    @(negedge clk);
    wr_ready = 1'b0;
    send(12'h501, 12'h601, 32'h11);
    expect_rec("R10 held", 16'h0100, 12'h501, 12'h601, 32'h11);
    send(12'h502, 12'h602, 32'h22);
    expect_rec("R10 stable", 16'h0100, 12'h501, 12'h601, 32'h11);
    check("R11 drop one", {48'd0, drop_count}, 64'd1);
    wr_ready = 1'b1;
    @(negedge clk);
    expect_none("R10 drained");
    send(12'h503, 12'h603, 32'h33);
    expect_rec("R11 no slot used", 16'h0101, 12'h503, 12'h603, 32'h33);
    check("R11 count kept", {48'd0, drop_count}, 64'd1);
    restart(16'h0100, 16'h01FF, 1'b1);
    check("R11 cleared", {48'd0, drop_count}, 64'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_nofilter();
    t_dst();
    t_src();
    t_both();
    t_wrap();
    t_stop();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule